// File: doc/BRIEF.md
# Transfer Setup Register Block with Split Address Counter

This block is the slave-side register front end of a peripheral that masters a system bus. Software programs it with word-wide writes to two registers. The control word carries a start strobe, a two-bit function code, the two most significant bits of the transfer address and an interrupt enable. The second register carries the lower sixteen address bits. Internally the two pieces form one 18-bit physical address counter. The counter advances on every completed bus cycle, and a carry out of the lower register ripples into the extension bits held in the control word.

A small engine takes a word count, raises a bus request for each word and waits for an acknowledge. At the end it flags completion and, if enabled, raises an interrupt request. Bus arbitration and the data path are not part of the block. They are represented only by the request/acknowledge pair and the presented address and function code.

Top module: `dma_setup_regs`

## Requirements
- R1: After reset both registers read as 0x0000, and `busy`, `done`, `irq` and `bus_req` are all low.
- R2: A control write (`reg_sel`=0) stores the function code from bits 2:1, the address extension from bits 5:4 and the interrupt enable from bit 6. On readback, bits 15:7, bit 3 and bit 0 are always zero.
- R3: An address write (`reg_sel`=1) while idle loads address bits 15:0 in one write, and they read back unchanged.
- R4: A control write with bit 0 set while idle and a nonzero `xfer_words` starts a transfer. `busy` and `bus_req` are high from the next cycle, and bit 0 still reads as zero.
- R5: Each cycle with `bus_req` and `bus_ack` both high completes one word and advances the 18-bit address by 2. A carry out of bit 15 increments the extension bits, and the new value reads back through control bits 5:4.
- R6: While busy, writes to either register have no effect on the address, function, enable or the running transfer.
- R7: Exactly `xfer_words` requests are completed. After the last one, `busy` and `bus_req` fall and `done` is set.
- R8: `irq` rises at completion only if the interrupt enable is set.
- R9: Any control write clears `irq`, unless the same write completes a transfer.
- R10: A start with `xfer_words` of zero sets `done` on the next cycle and issues no request. `irq` follows the enable written by that same write.
- R11: The address wraps from 0x3FFFE to 0x00000 over its full 18 bits.
- R12: `bus_func` presents the stored function code during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 low address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| xfer_words | input | CNT_W | Word count, sampled at start |
| bus_req | output | 1 | Bus cycle request, one per word |
| bus_ack | input | 1 | Bus cycle completed |
| bus_addr | output | 18 | Current physical address |
| bus_func | output | 2 | Function code of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| irq | output | 1 | Interrupt request |

## Verification
The bench starts a transfer just below a 64 KiB boundary. A counter that dropped the carry into the extension bits would present an address 64 KiB too low and read back a stale extension field. It also runs from the top of the 18-bit space, where an unmasked counter would leave a nineteenth bit standing. Register writes arrive in the middle of a transfer that is stalled by an alternating acknowledge; a design that honoured them would jump the address or restart the count. A zero-length start must finish with no request at all, since a design that loaded and decremented first would underflow and run for 65535 words. The interrupt is checked with the enable both set and clear.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int unsigned XR_W    = 16;
  localparam int unsigned EXT_W   = 2;
  localparam int unsigned ADDR_W  = XR_W + EXT_W;
  localparam int unsigned GO_BIT  = 0;
  localparam int unsigned FN_LO   = 1;
  localparam int unsigned EXT_LO  = 4;
  localparam int unsigned IE_BIT  = 6;

  typedef struct packed {
    logic             ie;
    logic [EXT_W-1:0] ext;
    logic [1:0]       fn;
  } xr_ctrl_t;

  // Next physical address after one word, wrapping at ADDR_W bits.
  function automatic logic [ADDR_W-1:0] xr_addr_step(input logic [ADDR_W-1:0] a,
                                                     input logic [ADDR_W-1:0] inc);
    return a + inc;
  endfunction

  // Control word as seen on readback: unused and strobe bits read zero.
  function automatic logic [XR_W-1:0] xr_ctrl_pack(input xr_ctrl_t c);
    logic [XR_W-1:0] w;
    w = '0;
    w[IE_BIT]                 = c.ie;
    w[EXT_LO +: EXT_W]        = c.ext;
    w[FN_LO +: 2]             = c.fn;
    return w;
  endfunction

  function automatic xr_ctrl_t xr_ctrl_unpack(input logic [XR_W-1:0] w);
    xr_ctrl_t c;
    c.ie  = w[IE_BIT];
    c.ext = w[EXT_LO +: EXT_W];
    c.fn  = w[FN_LO +: 2];
    return c;
  endfunction
endpackage

// File: rtl/xr_regs.sv
module xr_regs
  import xr_pkg::*;
#(
  parameter int unsigned ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              lo_we,
  input  logic [XR_W-1:0]   wdata,
  input  logic              lock,
  input  logic              step,
  output logic [1:0]        fn,
  output logic              ie,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);

  xr_ctrl_t wc;
  assign wc = xr_ctrl_unpack(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      fn   <= '0;
      ie   <= 1'b0;
    end else if (step) begin
      addr <= xr_addr_step(addr, STEP_V);
    end else if (!lock) begin
      if (ctrl_we) begin
        addr[ADDR_W-1:XR_W] <= wc.ext;
        fn                  <= wc.fn;
        ie                  <= wc.ie;
      end
      if (lo_we) addr[XR_W-1:0] <= wdata;
    end
  end

  // R5: the counter moves by exactly one step per completed word
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr == ADDR_W'($past(addr) + ADDR_STEP));

  // R6: while locked and not stepping, address and settings stay put
  assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !step) |=> ($stable(addr) && $stable(fn) && $stable(ie)));
endmodule

// File: rtl/xr_engine.sv
module xr_engine #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] words,
  input  logic             ack,
  input  logic             ie_fin,
  input  logic             irq_clr,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             step,
  output logic             fin
);
  logic [CNT_W-1:0] remaining;
  logic             zero_start;
  logic             last;

  assign zero_start = start && (words == '0);
  assign step       = busy && ack;
  assign last       = step && (remaining == CNT_W'(1));
  assign fin        = last || zero_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remaining <= '0;
      done      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (start && !zero_start) begin
        busy      <= 1'b1;
        remaining <= words;
      end else if (step) begin
        remaining <= remaining - CNT_W'(1);
        if (last) busy <= 1'b0;
      end
      if (fin)        done <= 1'b1;
      else if (start) done <= 1'b0;
      if (fin && ie_fin) irq <= 1'b1;
      else if (irq_clr)  irq <= 1'b0;
    end
  end

  // R7: completion ends the transfer
  assert_fin_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!busy && done));

  // R8: enabled completion raises the interrupt
  assert_irq_on_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ie_fin) |=> irq);

  // R8: no interrupt appears without an enabled completion
  assert_irq_needs_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(fin && ie_fin)) |=> !irq);

  // R9: a control write clears a pending interrupt
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fin) |=> !irq);

  // R10: zero-length start completes without going busy
  assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (done && !busy));
endmodule

// File: rtl/dma_setup_regs.sv
module dma_setup_regs
  import xr_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [CNT_W-1:0]  xfer_words,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [17:0]       bus_addr,
  output logic [1:0]        bus_func,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic              ctrl_we;
  logic              lo_we;
  logic              start;
  logic              step;
  logic              fin;
  logic              ie;
  logic              ie_fin;
  logic [1:0]        fn;
  logic [ADDR_W-1:0] addr;
  xr_ctrl_t          rd_ctrl;

  assign ctrl_we = reg_we && !reg_sel;
  assign lo_we   = reg_we &&  reg_sel;
  assign start   = ctrl_we && !busy && reg_wdata[GO_BIT];
  // a zero-length start finishes on the writing cycle: use the enable being written
  assign ie_fin  = (ctrl_we && !busy) ? reg_wdata[IE_BIT] : ie;

  xr_regs #(.ADDR_STEP(ADDR_STEP)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_we(ctrl_we),
    .lo_we  (lo_we),
    .wdata  (reg_wdata),
    .lock   (busy),
    .step   (step),
    .fn     (fn),
    .ie     (ie),
    .addr   (addr)
  );

  xr_engine #(.CNT_W(CNT_W)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .words  (xfer_words),
    .ack    (bus_ack),
    .ie_fin (ie_fin),
    .irq_clr(ctrl_we),
    .busy   (busy),
    .done   (done),
    .irq    (irq),
    .step   (step),
    .fin    (fin)
  );

  assign rd_ctrl.ie  = ie;
  assign rd_ctrl.ext = addr[ADDR_W-1:XR_W];
  assign rd_ctrl.fn  = fn;

  assign reg_rdata = reg_sel ? addr[XR_W-1:0] : xr_ctrl_pack(rd_ctrl);
  assign bus_req   = busy;
  assign bus_addr  = addr;
  assign bus_func  = fn;

  // R5: the bus address advances by the step after each handshake
  assert_bus_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> bus_addr == 18'($past(bus_addr) + ADDR_STEP));

  // R4: a start either runs or completes at once
  assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy || done));

  // R12: the function code holds through a transfer
  assert_func_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_func));
endmodule

// File: tb/sim_dma_setup_regs.sv
module sim_dma_setup_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] xfer_words = '0;
  logic        bus_req;
  logic        bus_ack = 1'b0;
  logic [17:0] bus_addr;
  logic [1:0]  bus_func;
  logic        busy, done, irq;

  int total = 0;
  int fails = 0;
  int ack_mode = 0;
  logic [17:0] exp_q[$];
  logic [1:0]  exp_fn = '0;

  always #5 clk = ~clk;

  dma_setup_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_words(xfer_words),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_func(bus_func), .busy(busy), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input bit s, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input bit s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  // driver: push expected addresses, then program and start
  task automatic start_xfer(input logic [1:0] ext, input logic [15:0] lo,
                            input logic [15:0] words, input logic [1:0] fn,
                            input bit ie);
    logic [17:0] a;
    a = {ext, lo};
    exp_fn = fn;
    for (int i = 0; i < int'(words); i++) begin
      exp_q.push_back(a);
      a = a + 18'd2;
    end
    reg_write(1'b1, lo);
    xfer_words = words;
    reg_write(1'b0, {9'b0, ie, ext, 1'b0, fn, 1'b1});
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  // acknowledge driver, changes away from the edges
  initial forever begin
    @(posedge clk);
    #2;
    bus_ack = (ack_mode == 0) ? 1'b1 : ~bus_ack;
  end

  // monitor: every handshake pops one expected address
  initial forever begin
    @(negedge clk);
    if (rst_n && bus_req && bus_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 extra request", {14'b0, bus_addr}, 32'h0);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        chk(bus_addr == e, "R5 R11 address", {14'b0, bus_addr}, {14'b0, e});
        chk(bus_func == exp_fn, "R12 function", {30'b0, bus_func}, {30'b0, exp_fn});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); chk(v == 16'h0, "R1 ctrl reset", {16'b0, v}, 32'h0);
    rd(1'b1, v); chk(v == 16'h0, "R1 addr reset", {16'b0, v}, 32'h0);
    chk({busy, done, irq, bus_req} == 4'b0, "R1 flags", {28'b0, busy, done, irq, bus_req}, 32'h0);

    // R2 field masking: 0xFFFE -> ie, ext=3, fn=3 only
    reg_write(1'b0, 16'hFFFE);
    rd(1'b0, v); chk(v == 16'h0076, "R2 ctrl mask", {16'b0, v}, 32'h76);
    chk(!busy, "R2 no start without go", {31'b0, busy}, 32'h0);

    // R3 address low load
    reg_write(1'b1, 16'hA5C3);
    rd(1'b1, v); chk(v == 16'hA5C3, "R3 addr load", {16'b0, v}, 32'hA5C3);

    // R4 R5 carry across the 16-bit boundary, ie set, fn=2
    ack_mode = 0;
    start_xfer(2'd0, 16'hFFFC, 16'd4, 2'd2, 1'b1);
    chk(busy && bus_req, "R4 busy after go", {30'b0, busy, bus_req}, 32'h3);
    rd(1'b0, v); chk(v[0] == 1'b0, "R4 go reads zero", {16'b0, v}, 32'h0);
    wait_idle();
    chk(exp_q.size() == 0, "R7 all words done", exp_q.size(), 32'h0);
    chk(done && !bus_req, "R7 done", {30'b0, done, bus_req}, 32'h2);
    chk(irq, "R8 irq with ie", {31'b0, irq}, 32'h1);
    rd(1'b0, v); chk(v == 16'h0054, "R5 ext carry readback", {16'b0, v}, 32'h54);
    rd(1'b1, v); chk(v == 16'h0004, "R5 low after carry", {16'b0, v}, 32'h4);

    // R9 control write clears irq (start bit clear)
    reg_write(1'b0, 16'h0054);
    chk(!irq, "R9 irq cleared", {31'b0, irq}, 32'h0);

    // R11 wrap at 18 bits, ie clear, fn=1
    start_xfer(2'd3, 16'hFFFE, 16'd2, 2'd1, 1'b0);
    wait_idle();
    chk(exp_q.size() == 0, "R11 words done", exp_q.size(), 32'h0);
    chk(!irq && done, "R8 no irq without ie", {30'b0, irq, done}, 32'h1);
    rd(1'b0, v); chk(v == 16'h0002, "R11 ctrl after wrap", {16'b0, v}, 32'h2);
    rd(1'b1, v); chk(v == 16'h0002, "R11 low after wrap", {16'b0, v}, 32'h2);

    // R6 writes during a stalled transfer are ignored; fn=3 ext=2 ie=1
    ack_mode = 1;
    start_xfer(2'd2, 16'h0100, 16'd6, 2'd3, 1'b1);
    reg_write(1'b1, 16'h1234);
    reg_write(1'b0, 16'h0077);
    chk(busy, "R6 transfer continues", {31'b0, busy}, 32'h1);
    wait_idle();
    chk(exp_q.size() == 0, "R6 words done", exp_q.size(), 32'h0);
    rd(1'b1, v); chk(v == 16'h010C, "R6 low unaffected", {16'b0, v}, 32'h10C);
    rd(1'b0, v); chk(v == 16'h0066, "R6 ctrl unaffected", {16'b0, v}, 32'h66);
    chk(irq, "R8 irq after stalled run", {31'b0, irq}, 32'h1);

    // R10 zero length, ie set in the same write
    ack_mode = 0;
    reg_write(1'b0, 16'h0000);
    chk(!irq, "R9 clear before zero run", {31'b0, irq}, 32'h0);
    start_xfer(2'd0, 16'h0040, 16'd0, 2'd0, 1'b1);
    chk(done && irq && !busy && !bus_req, "R10 zero length",
        {28'b0, done, irq, busy, bus_req}, 32'hC);
    repeat (4) @(negedge clk);
    chk(!bus_req, "R10 no request", {31'b0, bus_req}, 32'h0);
    rd(1'b1, v); chk(v == 16'h0040, "R10 address unchanged", {16'b0, v}, 32'h40);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule